// File: doc/BRIEF.md
# Cascadable Display-RAM I2C Slave

This block is the serial front end of a display driver that is meant to be cascaded. Several identical drivers can sit on one I2C bus and share a single slave address. The block answers a 7-bit address of the form 011110x, where the low bit comes from a strap pin. After the address it takes a run of command bytes. Every device on that address acknowledges those commands together. Once the commands end, the block moves a stream of bytes between the bus and a local display RAM.

Each device also has a 4-bit hardware subaddress strap. An internal subaddress counter picks which device on the shared address owns the data phase. Only the device whose strap equals the counter acknowledges and stores the data bytes, or drives them back in read mode. A data pointer advances after every data byte. When the pointer wraps past the end of the RAM, the subaddress counter steps on to the next device, so a single long stream can fill the display RAM of every device in the cascade.

SCL and SDA are oversampled by the system clock. SDA is open-drain, so the block only drives an output enable that pulls the line low.

Top module: `disp_i2c_slave`

## Requirements
- R1: An address byte whose upper seven bits equal {011110, sa0_i} is acknowledged: SDA is pulled low during the ninth SCL pulse. This happens whatever the subaddress strap holds. The lowest bit of the byte selects read (1) or write (0).
- R2: An address byte that does not match is not acknowledged. All later bytes up to the next start are then ignored: no ACK, no RAM write, no pointer change.
- R3: In write mode every command byte is acknowledged by every device on the matching address, whether or not its strap equals the subaddress counter.
- R4: Bit 7 of a command byte is the continuation flag. A value of 1 means another command follows. A value of 0 marks the last command, and every later byte of the transfer is display data.
- R5: A command with bit 6 = 0 loads the data pointer from bits 5..0. A command with bits 6..4 = 111 loads the subaddress counter from bits 3..0.
- R6: A data byte is acknowledged and written to RAM only when subaddr_i equals the subaddress counter. Otherwise SDA stays released and the RAM is untouched.
- R7: After reset the pointer and counter are 0. The pointer increments after every data byte, whether or not the byte is acknowledged. When it steps past the last RAM address it returns to 0 and the subaddress counter increments modulo 16. The pointer is visible on ram_addr_o.
- R8: In read mode the block drives RAM[pointer] MSB first, starting in the clock after the address ACK. It continues with the next byte while the master acknowledges. It drives only while its strap equals the counter; otherwise the master reads 0xFF.
- R9: After a master NACK on a read byte the block releases SDA and drives nothing more until the next start.
- R10: A repeated start or a stop aborts the current phase. The next byte after a start is always treated as an address byte, followed by the command phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sa0_i | input | 1 | Strap for the slave address low bit |
| subaddr_i | input | 4 | Hardware subaddress strap |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | AW | RAM address (the data pointer) |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data for ram_addr_o, combinational |

## Verification
Every change of sda_oe_o follows an SCL edge. The edge passes through two synchroniser flops and one edge-detect register, so the output moves about three system clocks after the bus edge. The bench holds each SCL phase for sixteen clocks and samples SDA in the middle of the high phase, well after that latency has passed. RAM writes happen in the same clock that detects the SCL fall ending the eighth bit, and the pointer updates in that same clock. The bench therefore reads its RAM model and ram_addr_o only after at least one further bus bit or the stop condition, never close to the edge.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } state_t;

  localparam logic [5:0] DEV_ADDR_HI = 6'b011110;
  localparam logic [2:0] SUB_OP      = 3'b111;
  localparam int         CONT_BIT    = 7;
endpackage

// File: rtl/disp_i2c_sync.sv
module disp_i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  // idle bus lines are high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '1;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/disp_i2c_ptr.sv
module disp_i2c_ptr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_ptr_i,
  input  logic [AW-1:0] ld_ptr_val_i,
  input  logic          ld_sub_i,
  input  logic [3:0]    ld_sub_val_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic [3:0]    sub_o
);
  localparam logic [AW-1:0] PTR_LAST = '1;

  logic [AW-1:0] ptr_q;
  logic [3:0]    sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      sub_q <= '0;
    end else begin
      if (ld_ptr_i) ptr_q <= ld_ptr_val_i;
      else if (adv_i) begin
        if (ptr_q == PTR_LAST) begin
          ptr_q <= '0;
          sub_q <= sub_q + 4'd1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
      if (ld_sub_i) sub_q <= ld_sub_val_i;
    end
  end

  assign ptr_o = ptr_q;
  assign sub_o = sub_q;

  // R7
  ptr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_ptr_i && !ld_sub_i && ptr_q != PTR_LAST) |=>
      (ptr_q == $past(ptr_q) + 1'b1 && sub_q == $past(sub_q)));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_ptr_i && !ld_sub_i && ptr_q == PTR_LAST) |=>
      (ptr_q == '0 && sub_q == $past(sub_q) + 4'd1));

  // R5
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ptr_i |=> ptr_q == $past(ld_ptr_val_i));
endmodule

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave
  import disp_i2c_pkg::*;
#(
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          sa0_i,
  input  logic [3:0]    subaddr_i,
  output logic          sda_oe_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  input  logic [7:0]    ram_rdata_i
);
  logic [1:0] sync_q;
  logic       scl_s, sda_s, scl_d, sda_d;

  disp_i2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (sync_q)
  );

  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  state_t        state_q, after_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    sh_q, tx_q;
  logic          oe_q, mack_q;
  logic [AW-1:0] ptr;
  logic [3:0]    sub;
  logic          sel, byte_end, addr_hit, ld_ptr, ld_sub, adv;

  assign sel      = (sub == subaddr_i);
  assign byte_end = scl_fall & (bit_cnt_q == 4'd8);
  assign addr_hit = (sh_q[7:1] == {DEV_ADDR_HI, sa0_i});
  assign ld_ptr   = (state_q == ST_CMD) & byte_end & ~sh_q[6];
  assign ld_sub   = (state_q == ST_CMD) & byte_end & (sh_q[6:4] == SUB_OP);
  assign adv      = byte_end & ((state_q == ST_WDATA) | (state_q == ST_RDATA));

  disp_i2c_ptr #(.AW(AW)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ld_ptr_i     (ld_ptr),
    .ld_ptr_val_i (sh_q[AW-1:0]),
    .ld_sub_i     (ld_sub),
    .ld_sub_val_i (sh_q[3:0]),
    .adv_i        (adv),
    .ptr_o        (ptr),
    .sub_o        (sub)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      after_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
      mack_q    <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_end) begin
            bit_cnt_q <= '0;
            state_q   <= ST_ACK;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                oe_q    <= 1'b1;
                after_q <= sh_q[0] ? ST_RDATA : ST_CMD;
              end else begin
                state_q <= ST_IDLE;  // wait for next start
              end
            end else if (state_q == ST_CMD) begin
              oe_q    <= 1'b1;
              after_q <= sh_q[CONT_BIT] ? ST_CMD : ST_WDATA;
            end else begin
              oe_q    <= sel;
              after_q <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_q      <= 1'b0;
            state_q   <= after_q;
            bit_cnt_q <= '0;
            if (after_q == ST_RDATA) begin
              tx_q <= ram_rdata_i;
              oe_q <= sel & ~ram_rdata_i[7];
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q      <= 1'b0;
              state_q   <= ST_RACK;
              bit_cnt_q <= '0;
            end else if (bit_cnt_q != 4'd0) begin
              tx_q <= tx_q << 1;
              oe_q <= sel & ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_RDATA;
              tx_q    <= ram_rdata_i;
              oe_q    <= sel & ~ram_rdata_i[7];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o    = oe_q;
  assign ram_we_o    = (state_q == ST_WDATA) & byte_end & sel;
  assign ram_addr_o  = ptr;
  assign ram_wdata_o = sh_q;

  // R10
  start_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR && bit_cnt_q == 4'd0));

  // R10
  stop_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !oe_q));

  // R9
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s);

  // R6
  wdata_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> (oe_q && state_q == ST_ACK));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!oe_q && !ram_we_o));
endmodule

// File: tb/tb_disp_i2c_slave.sv
module tb_disp_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, sa0 = 1'b0;
  logic [3:0] strap = 4'd0;
  logic sda_oe, ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic sda_bus;
  logic [7:0] mem [1<<AW];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= 8'h00;
    end else if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
    end
  end
  assign ram_rdata = mem[ram_addr];

  disp_i2c_slave #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sa0_i(sa0),
    .subaddr_i(strap), .sda_oe_o(sda_oe), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    wclk(8); sda_m = 1'b1; wclk(8); scl = 1'b1; wclk(8);
    sda_m = 1'b0; wclk(8); scl = 1'b0;
  endtask

  task automatic i2c_stop;
    wclk(8); sda_m = 1'b0; wclk(8); scl = 1'b1; wclk(8);
    sda_m = 1'b1; wclk(16);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wclk(8); sda_m = b[i]; wclk(8); scl = 1'b1; wclk(16); scl = 1'b0;
    end
    wclk(8); sda_m = 1'b1; wclk(8); scl = 1'b1; wclk(8);
    ack = !sda_bus;
    wclk(8); scl = 1'b0;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wclk(8); sda_m = 1'b1; wclk(8); scl = 1'b1; wclk(8);
      b[i] = sda_bus;
      wclk(8); scl = 1'b0;
    end
    wclk(8); sda_m = !give_ack; wclk(8); scl = 1'b1; wclk(16); scl = 1'b0;
    wclk(8); sda_m = 1'b1;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R7 reset oe", sda_oe, 0);
    chk(ram_we == 1'b0, "R7 reset we", ram_we, 0);
    chk(ram_addr == 0, "R7 reset ptr", ram_addr, 0);
  endtask

  task automatic t_basic_write;
    bit a;
    strap = 4'd0;
    i2c_start;
    put_byte(8'h78, a); chk(a, "R1 addr ack", a, 1);
    put_byte(8'h85, a); chk(a, "R3 cmd ack", a, 1);
    put_byte(8'h70, a); chk(a, "R4 last cmd ack", a, 1);
    put_byte(8'hA5, a); chk(a, "R6 data ack", a, 1);
    put_byte(8'h5A, a); chk(a, "R6 data ack 2", a, 1);
    i2c_stop;
    chk(mem[5] == 8'hA5, "R5 write at ptr", mem[5], 8'hA5);
    chk(mem[6] == 8'h5A, "R7 ptr increment", mem[6], 8'h5A);
    // strap no longer matches counter 0
    strap = 4'd3;
    i2c_start;
    put_byte(8'h78, a); chk(a, "R1 addr ack any strap", a, 1);
    put_byte(8'h09, a); chk(a, "R3 cmd ack any strap", a, 1);
    put_byte(8'hC3, a); chk(!a, "R6 no ack on mismatch", a, 0);
    i2c_stop;
    chk(mem[9] == 8'h00, "R6 no write on mismatch", mem[9], 0);
    chk(ram_addr == 10, "R7 ptr advances unacked", ram_addr, 10);
  endtask

  task automatic t_addr_mismatch;
    bit a;
    sa0 = 1'b1;
    i2c_start;
    put_byte(8'h78, a); chk(!a, "R2 wrong addr nack", a, 0);
    put_byte(8'h85, a); chk(!a, "R2 later byte ignored", a, 0);
    put_byte(8'h99, a); chk(!a, "R2 later byte ignored 2", a, 0);
    i2c_stop;
    chk(ram_addr == 10, "R2 ptr untouched", ram_addr, 10);
    i2c_start;
    put_byte(8'h7A, a); chk(a, "R1 sa0 strap addr ack", a, 1);
    i2c_stop;
    sa0 = 1'b0;
  endtask

  task automatic t_wrap;
    bit a;
    strap = 4'd0;
    i2c_start;
    put_byte(8'h78, a);
    put_byte(8'hBE, a);
    put_byte(8'h70, a);
    put_byte(8'h01, a); chk(a, "R7 ack at 62", a, 1);
    put_byte(8'h02, a); chk(a, "R7 ack at 63", a, 1);
    put_byte(8'h03, a); chk(!a, "R7 next device after wrap", a, 0);
    i2c_stop;
    chk(mem[63] == 8'h02, "R7 last addr written", mem[63], 8'h02);
    chk(mem[0] == 8'h00, "R7 wrap not written", mem[0], 0);
    chk(ram_addr == 1, "R7 ptr wrapped", ram_addr, 1);
    strap = 4'd1;
    i2c_start;
    put_byte(8'h78, a);
    put_byte(8'h00, a);
    put_byte(8'h04, a); chk(a, "R7 counter now 1", a, 1);
    i2c_stop;
    chk(mem[0] == 8'h04, "R7 write after wrap", mem[0], 8'h04);
  endtask

  task automatic t_read;
    bit a;
    logic [7:0] b;
    strap = 4'd1;
    i2c_start;
    put_byte(8'h78, a);
    put_byte(8'h85, a);
    put_byte(8'h71, a);
    i2c_stop;
    i2c_start;
    put_byte(8'h79, a); chk(a, "R1 read addr ack", a, 1);
    get_byte(1'b1, b); chk(b == 8'hA5, "R8 read byte 1", b, 8'hA5);
    get_byte(1'b0, b); chk(b == 8'h5A, "R8 read byte 2", b, 8'h5A);
    chk(sda_oe == 1'b0, "R9 release after nack", sda_oe, 0);
    get_byte(1'b0, b); chk(b == 8'hFF, "R9 silent after nack", b, 8'hFF);
    i2c_stop;
    chk(ram_addr == 7, "R8 ptr after reads", ram_addr, 7);
    strap = 4'd2;
    i2c_start;
    put_byte(8'h79, a); chk(a, "R1 read addr ack other strap", a, 1);
    get_byte(1'b0, b); chk(b == 8'hFF, "R8 unselected read", b, 8'hFF);
    i2c_stop;
  endtask

  task automatic t_abort;
    bit a;
    strap = 4'd1;
    i2c_start;
    put_byte(8'h78, a);
    put_byte(8'h8A, a);
    put_byte(8'h71, a);
    put_byte(8'h33, a); chk(a, "R6 data before restart", a, 1);
    i2c_start;
    put_byte(8'h78, a); chk(a, "R10 restart addr ack", a, 1);
    put_byte(8'h14, a); chk(a, "R10 byte is command", a, 1);
    chk(mem[11] == 8'h00, "R10 no data write", mem[11], 0);
    chk(ram_addr == 20, "R10 ptr loaded", ram_addr, 20);
    put_byte(8'h44, a);
    i2c_stop;
    chk(mem[20] == 8'h44, "R4 data after last cmd", mem[20], 8'h44);
    chk(mem[10] == 8'h33, "R6 data stored", mem[10], 8'h33);
    i2c_start;
    put_byte(8'h78, a);
    put_byte(8'h16, a);
    i2c_stop;
    chk(ram_addr == 22, "R10 after stop cmd phase", ram_addr, 22);
    chk(mem[21] == 8'h00, "R10 stop no data", mem[21], 0);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset;
    t_basic_write;
    t_addr_mismatch;
    t_wrap;
    t_read;
    t_abort;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule